// File: doc/BRIEF.md
# Phase Alarm Timeout Monitor

This block watches the state code of a digital PLL's lock state machine and the index of the input the PLL is currently trying to lock to. Time is counted in whole seconds from a one-second strobe, but only while the machine sits in one of its "trying but not locked" states. If that time reaches a programmed limit, the block raises a phase alarm on the selected input. The limit is a 6-bit field scaled at two seconds per count.

Each input has its own alarm bit. A mode input picks how alarms end. In sticky mode an alarm stays set until software clears it with a per-input clear. In auto mode each alarm also drops by itself 128 seconds after it was raised. Every input has its own expiry count, so several alarms can expire at different times. The accumulated time restarts whenever the PLL reaches lock or the selected input changes.

Top module: `phase_alarm_monitor`

## Requirements
- R1: While reset is asserted and just after it, every alarm bit is 0.
- R2: State codes on `pll_state` are 1 (pre-lock A), 2 (pre-lock B) and 5 (phase lost) for the qualifying states, 3 and 4 for the locked states, and 0, 6 and 7 for the others. Time accumulates, and an alarm can be raised, only in a qualifying state. An alarm is raised only on the bit whose index equals `sel_input`.
- R3: With timeout field T, the alarm is raised on the strobe that brings the accumulated qualifying time to 2*T seconds. With T = 0 it is raised on the first qualifying strobe. Alarm bits change only on a strobe or a software clear.
- R4: A locked state (3 or 4) clears the accumulated time. The other non-qualifying states (0, 6, 7) hold the accumulated time without adding to it.
- R5: A change of `sel_input` clears the accumulated time, so the new input starts from zero.
- R6: With `auto_expire` = 0, a raised alarm stays set, however many strobes pass, until its `sw_clear` bit is pulsed.
- R7: With `auto_expire` = 1, an alarm clears on the 128th strobe after the strobe that raised it. Each input keeps its own count.
- R8: A `sw_clear` bit asserted in the same cycle as a raise on that input wins, and the alarm stays 0.
- R9: The reset value of the timeout register is 0x32, which gives a field of 50. With that field, the alarm is raised on the 100th qualifying strobe and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| pll_state | input | 3 | Lock state machine code |
| sel_input | input | SEL_W | Index of the input being locked to |
| timeout_cfg | input | TO_W | Timeout field, in units of two seconds |
| auto_expire | input | 1 | 1: alarms expire after 128 s; 0: sticky |
| sw_clear | input | N_INPUTS | Per-input alarm clear, one-cycle pulse |
| alarm | output | N_INPUTS | Per-input phase alarm |

## Verification
The assertions check the following on every cycle:
- the reset value;
- that an alarm rises only after a strobe in a qualifying state on the selected index;
- that a clear always wins;
- that sticky alarms hold;
- that an alarm falls only on a clear or an auto-mode strobe.

The exact strobe on which an alarm rises or expires needs the bench's directed scenarios. So does the clearing of accumulated time on lock or on an input change, and the hold in the other states.

// File: rtl/phase_alarm_monitor.sv
module phase_alarm_monitor #(
  parameter int N_INPUTS     = 4,
  parameter int TO_W         = 6,
  parameter int EXPIRE_TICKS = 128,
  localparam int SEL_W       = (N_INPUTS > 1) ? $clog2(N_INPUTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_tick,
  input  logic [2:0]          pll_state,
  input  logic [SEL_W-1:0]    sel_input,
  input  logic [TO_W-1:0]     timeout_cfg,
  input  logic                auto_expire,
  input  logic [N_INPUTS-1:0] sw_clear,
  output logic [N_INPUTS-1:0] alarm
);
  localparam int ACC_W = TO_W + 1;
  localparam int EXP_W = $clog2(EXPIRE_TICKS);
  localparam logic [EXP_W-1:0] EXP_LAST = EXP_W'(EXPIRE_TICKS - 1);

  logic [ACC_W-1:0]    acc;
  logic [SEL_W-1:0]    sel_q;
  logic [N_INPUTS-1:0] alarm_q;

  wire qual    = (pll_state == 3'd1) || (pll_state == 3'd2) || (pll_state == 3'd5);
  wire locked  = (pll_state == 3'd3) || (pll_state == 3'd4);
  wire acc_clr = locked || (sel_input != sel_q);
  wire step    = sec_tick && qual && !acc_clr;
  wire reached = ((ACC_W+1)'(acc) + (ACC_W+1)'(1)) >= {1'b0, timeout_cfg, 1'b0};
  wire raise   = step && reached;
  wire [N_INPUTS-1:0] set_vec = raise ? (N_INPUTS'(1) << sel_input) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel_input;
      if (acc_clr)
        acc <= '0;
      else if (step && acc != '1)
        acc <= acc + 1'b1;
    end
  end

  for (genvar i = 0; i < N_INPUTS; i++) begin : g_in
    logic [EXP_W-1:0] exp_cnt;
    wire expire = auto_expire && sec_tick && alarm_q[i] && (exp_cnt == EXP_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alarm_q[i] <= 1'b0;
        exp_cnt    <= '0;
      end else begin
        alarm_q[i] <= ((alarm_q[i] && !expire) || set_vec[i]) && !sw_clear[i];
        if (sw_clear[i] || !alarm_q[i] || expire)
          exp_cnt <= '0;
        else if (auto_expire && sec_tick)
          exp_cnt <= exp_cnt + 1'b1;
      end
    end
  end

  assign alarm = alarm_q;
endmodule

// File: rtl/phase_alarm_monitor_sva.sv
module phase_alarm_monitor_sva #(
  parameter int N_INPUTS = 4,
  parameter int SEL_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sec_tick,
  input logic [2:0]          pll_state,
  input logic [SEL_W-1:0]    sel_input,
  input logic                auto_expire,
  input logic [N_INPUTS-1:0] sw_clear,
  input logic [N_INPUTS-1:0] alarm
);
  wire qual = (pll_state == 3'd1) || (pll_state == 3'd2) || (pll_state == 3'd5);

  always @(posedge clk)
    if (!rst_n) p_reset_zero_r1: assert (alarm == '0);

  for (genvar i = 0; i < N_INPUTS; i++) begin : g_chk
    p_raise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm[i]) |-> $past(sec_tick) && $past(qual) && ($past(sel_input) == SEL_W'(i)));
    p_strobe_paced_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick && !sw_clear[i] |=> $stable(alarm[i]));
    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm[i] && !auto_expire && !sw_clear[i] |=> alarm[i]);
    p_fall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm[i]) |-> $past(sw_clear[i]) || ($past(auto_expire) && $past(sec_tick)));
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clear[i] |=> !alarm[i]);
  end
endmodule

bind phase_alarm_monitor phase_alarm_monitor_sva #(.N_INPUTS(N_INPUTS), .SEL_W(SEL_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pll_state(pll_state),
  .sel_input(sel_input), .auto_expire(auto_expire), .sw_clear(sw_clear), .alarm(alarm)
);

// File: tb/phase_alarm_monitor_tb.sv
module phase_alarm_monitor_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sec_tick = 1'b0;
  logic [2:0]   pll_state = 3'd0;
  logic [1:0]   sel_input = 2'd0;
  logic [5:0]   timeout_cfg = 6'd0;
  logic         auto_expire = 1'b0;
  logic [N-1:0] sw_clear = '0;
  logic [N-1:0] alarm;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  phase_alarm_monitor #(.N_INPUTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pll_state(pll_state),
    .sel_input(sel_input), .timeout_cfg(timeout_cfg), .auto_expire(auto_expire),
    .sw_clear(sw_clear), .alarm(alarm)
  );

  task automatic check(input string req, input logic [N-1:0] exp);
    checks++;
    if (alarm !== exp) begin
      fails++;
      $display("FAIL %s: alarm actual %b expected %b", req, alarm, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sec_tick = 1'b0; sw_clear = '0; pll_state = 3'd0; sel_input = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 during reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0);
  endtask

  task automatic t_basic_timeout();
    do_reset();
    timeout_cfg = 6'd2; auto_expire = 1'b0; sel_input = 2'd1; pll_state = 3'd1;
    @(negedge clk);
    tick(3);
    check("R3 before 2*T strobes", '0);
    tick(1);
    check("R3 R2 raised on selected bit", 4'b0010);
  endtask

  task automatic t_zero_timeout();
    do_reset();
    timeout_cfg = 6'd0; sel_input = 2'd2; pll_state = 3'd5;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R3 no change without strobe", '0);
    tick(1);
    check("R3 zero timeout first strobe", 4'b0100);
  endtask

  task automatic t_nonqual();
    do_reset();
    timeout_cfg = 6'd0; sel_input = 2'd0;
    pll_state = 3'd0; tick(5);
    check("R2 free state no alarm", '0);
    pll_state = 3'd6; tick(5);
    check("R2 state 6 no alarm", '0);
    pll_state = 3'd4; tick(3);
    check("R2 locked no alarm", '0);
  endtask

  task automatic t_lock_and_hold();
    do_reset();
    timeout_cfg = 6'd3; sel_input = 2'd3;
    pll_state = 3'd2; tick(4);
    pll_state = 3'd3; @(negedge clk); @(negedge clk);
    pll_state = 3'd2; tick(5);
    check("R4 lock restarted time", '0);
    tick(1);
    check("R4 raised 6 s after lock", 4'b1000);
    do_reset();
    timeout_cfg = 6'd3; sel_input = 2'd3;
    pll_state = 3'd2; tick(4);
    pll_state = 3'd7; tick(3);
    pll_state = 3'd2; tick(1);
    check("R4 held time, 5 s", '0);
    tick(1);
    check("R4 held time, raised at 6 s", 4'b1000);
  endtask

  task automatic t_sel_change();
    do_reset();
    timeout_cfg = 6'd2; sel_input = 2'd0; pll_state = 3'd1;
    @(negedge clk);
    tick(3);
    sel_input = 2'd3;
    @(negedge clk);
    tick(3);
    check("R5 new input restarted", '0);
    tick(1);
    check("R5 alarm only on new input", 4'b1000);
  endtask

  task automatic t_sticky();
    do_reset();
    timeout_cfg = 6'd0; auto_expire = 1'b0; sel_input = 2'd0; pll_state = 3'd1;
    @(negedge clk);
    tick(1);
    check("R6 raised", 4'b0001);
    pll_state = 3'd0;
    tick(140);
    check("R6 sticky after 140 strobes", 4'b0001);
    sw_clear = 4'b0001; @(negedge clk); sw_clear = '0; @(negedge clk);
    check("R6 cleared by software", '0);
  endtask

  task automatic t_expire();
    do_reset();
    timeout_cfg = 6'd0; auto_expire = 1'b1; sel_input = 2'd0; pll_state = 3'd1;
    @(negedge clk);
    tick(1);
    pll_state = 3'd0;
    tick(10);
    sel_input = 2'd1; pll_state = 3'd1;
    @(negedge clk);
    tick(1);
    check("R7 two alarms set", 4'b0011);
    pll_state = 3'd0;
    tick(116);
    check("R7 bit0 at 127 strobes", 4'b0011);
    tick(1);
    check("R7 bit0 expired at 128, bit1 kept", 4'b0010);
    tick(10);
    check("R7 bit1 at 127 strobes", 4'b0010);
    tick(1);
    check("R7 bit1 expired at 128", '0);
    auto_expire = 1'b0;
  endtask

  task automatic t_clear_priority();
    do_reset();
    timeout_cfg = 6'd0; sel_input = 2'd2; pll_state = 3'd1;
    @(negedge clk);
    @(negedge clk); sec_tick = 1'b1; sw_clear = 4'b0100;
    @(negedge clk); sec_tick = 1'b0; sw_clear = '0;
    @(negedge clk);
    check("R8 clear beats raise", '0);
    tick(1);
    check("R8 raise without clear", 4'b0100);
  endtask

  task automatic t_default_cfg();
    do_reset();
    timeout_cfg = 6'h32; sel_input = 2'd1; pll_state = 3'd5;
    @(negedge clk);
    tick(99);
    check("R9 none at 99 s", '0);
    tick(1);
    check("R9 raised at 100 s", 4'b0010);
  endtask

  initial begin
    t_reset();
    t_basic_timeout();
    t_zero_timeout();
    t_nonqual();
    t_lock_and_hold();
    t_sel_change();
    t_sticky();
    t_expire();
    t_clear_priority();
    t_default_cfg();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule